// File: doc/BRIEF.md
# Dual-Slope Conversion Controller

This block holds the digital half of an integrating converter. An external integrator is charged from the analog input for a fixed number of clocks. It is then discharged from a negative reference while the same counter counts again from zero. The number of discharge clocks is proportional to the input and is latched as the result. The block drives a two-bit switch select that chooses ground, the analog input or the negative reference. It watches a comparator line that goes high once the integrator output is back at or above zero.

A conversion begins on a `start` pulse while idle. The comparator line is asynchronous and passes through a two-flop synchronizer before the controller uses it. If the discharge count would reach 2^CNT_W, the conversion is aborted and flagged as an overflow. Each finished conversion, normal or aborted, raises `done` for one clock. The result and overflow flag then hold until the next conversion finishes.

Top module: `dslope_ctrl`

## Requirements
- R1: While reset is high and right after it, `sw_sel` is 2'b00, `done` is 0, `overflow` is 0 and `result` is 0.
- R2: A `start` sampled high while idle (`sw_sel`=2'b00 and `done`=0) makes `sw_sel` 2'b01 (analog input) from the next cycle, for exactly RUNUP_COUNT consecutive cycles (default 2^CNT_W = 256).
- R3: After the charge phase, `sw_sel` goes directly from 2'b01 to 2'b10 (negative reference), and the discharge count restarts from zero.
- R4: The comparator passes through two flops. The discharge ends on the first cycle in which the synchronized comparator is high, and the result is the discharge count in that cycle. If the comparator first goes high in discharge cycle j (counted from 0), the result is j+2. If it is already high throughout, the result is 0.
- R5: When the result is latched, `done` is high for exactly one cycle, and `sw_sel` is 2'b00 in that cycle.
- R6: If the discharge count reaches 2^CNT_W-1 with the synchronized comparator still low, the conversion aborts. `overflow` becomes 1, `result` becomes all ones, and `done` pulses.
- R7: `result` and `overflow` change only in a `done` cycle. They hold through idle time and through the next conversion, and a normal conversion clears `overflow`.
- R8: `start` has no effect during the charge phase, the discharge phase or the `done` cycle.
- R9: `sw_sel` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion when idle |
| cmp_zero | input | 1 | Asynchronous comparator, high when the integrator is at or above zero |
| sw_sel | output | 2 | Switch select: 00 ground, 01 analog input, 10 negative reference |
| done | output | 1 | One-cycle pulse when a result is latched |
| overflow | output | 1 | Last conversion aborted at full count |
| result | output | CNT_W | Latched discharge count |

## Verification
The assertions check on every cycle that the switch code is legal, that `done` is a single-cycle pulse with the switch at ground, and that result and flag move only on `done`. They also check that an idle start enters the charge phase and that the charge phase lasts exactly RUNUP_COUNT cycles before going straight to the reference. Only the bench scenarios can show the exact discharge count, including the two-cycle synchronizer latency. They use a behavioural integrator at several input-to-reference ratios, which also covers the zero-input case and the boundary between a full-scale count and an overflow abort. The bench also shows that start pulses are ignored in mid-conversion.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RUNUP    = 2'd1,
    ST_RUNDOWN  = 2'd2,
    ST_DONE     = 2'd3
  } dsl_state_t;

  typedef enum logic [1:0] {
    SW_GND  = 2'b00,
    SW_VIN  = 2'b01,
    SW_NREF = 2'b10
  } dsl_sw_t;

  // switch position owned by each controller state
  function automatic dsl_sw_t sw_for(input dsl_state_t s);
    case (s)
      ST_RUNUP:   return SW_VIN;
      ST_RUNDOWN: return SW_NREF;
      default:    return SW_GND;
    endcase
  endfunction

endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dslope_counter.sv
module dslope_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
  import dslope_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int RUNUP_COUNT = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             zero_s,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic             latch,
  output logic             ovf_hit,
  output dsl_sw_t          sw,
  output logic             done
);
  localparam logic [CNT_W-1:0] RUNUP_LAST = CNT_W'(RUNUP_COUNT - 1);
  localparam logic [CNT_W-1:0] CNT_LAST   = '1;

  dsl_state_t state, nxt;

  always_comb begin
    nxt     = state;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    latch   = 1'b0;
    ovf_hit = 1'b0;
    case (state)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (start) nxt = ST_RUNUP;
      end
      ST_RUNUP: begin
        if (cnt == RUNUP_LAST) begin
          cnt_clr = 1'b1;
          nxt     = ST_RUNDOWN;
        end else begin
          cnt_en = 1'b1;
        end
      end
      ST_RUNDOWN: begin
        if (zero_s) begin
          latch = 1'b1;
          nxt   = ST_DONE;
        end else if (cnt == CNT_LAST) begin
          latch   = 1'b1;
          ovf_hit = 1'b1;
          nxt     = ST_DONE;
        end else begin
          cnt_en = 1'b1;
        end
      end
      default: begin
        cnt_clr = 1'b1;
        nxt     = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      sw    <= SW_GND;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      sw    <= sw_for(nxt);
      done  <= latch;
    end
  end
endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int RUNUP_COUNT = 1 << CNT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_zero,
  output logic [1:0]       sw_sel,
  output logic             done,
  output logic             overflow,
  output logic [CNT_W-1:0] result
);
  logic             zero_s;
  logic             cnt_clr, cnt_en, latch, ovf_hit;
  logic [CNT_W-1:0] cnt;
  dsl_sw_t          sw;

  dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_zero),
    .q   (zero_s)
  );

  dslope_counter #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .en  (cnt_en),
    .cnt (cnt)
  );

  dslope_fsm #(.CNT_W(CNT_W), .RUNUP_COUNT(RUNUP_COUNT)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .zero_s  (zero_s),
    .cnt     (cnt),
    .cnt_clr (cnt_clr),
    .cnt_en  (cnt_en),
    .latch   (latch),
    .ovf_hit (ovf_hit),
    .sw      (sw),
    .done    (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      overflow <= 1'b0;
    end else if (latch) begin
      result   <= ovf_hit ? '1 : cnt;
      overflow <= ovf_hit;
    end
  end

  assign sw_sel = sw;
endmodule

// File: rtl/dslope_chk.sv
module dslope_chk #(
  parameter int CNT_W       = 8,
  parameter int RUNUP_COUNT = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [1:0]       sw_sel,
  input logic             done,
  input logic             overflow,
  input logic [CNT_W-1:0] result
);
  localparam int LW = CNT_W + 2;
  logic [LW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)                  run_len <= '0;
    else if (sw_sel == 2'b01) run_len <= run_len + 1'b1;
    else                      run_len <= '0;
  end

  // R9
  sel_legal_chk: assert property (@(posedge clk) disable iff (rst) sw_sel != 2'b11);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R5
  done_gnd_chk: assert property (@(posedge clk) disable iff (rst) done |-> sw_sel == 2'b00);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(result));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(overflow));

  // R6
  ovf_full_chk: assert property (@(posedge clk) disable iff (rst) (done && overflow) |-> result == {CNT_W{1'b1}});

  // R2
  runup_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_sel == 2'b00 && !done && start) |=> sw_sel == 2'b01);

  // R3
  runup_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_sel == 2'b01) |=> (sw_sel == 2'b01 || sw_sel == 2'b10));

  // R2
  runup_max_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_sel == 2'b01) |-> (int'(run_len) < RUNUP_COUNT));

  // R2
  runup_len_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_sel == 2'b10 && run_len != '0) |-> (int'(run_len) == RUNUP_COUNT));
endmodule

bind dslope_ctrl dslope_chk #(.CNT_W(CNT_W), .RUNUP_COUNT(RUNUP_COUNT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .sw_sel   (sw_sel),
  .done     (done),
  .overflow (overflow),
  .result   (result)
);

// File: tb/tb_dslope_ctrl.sv
module tb_dslope_ctrl;
  localparam int CLK_P = 10;
  localparam int CNT_W = 8;
  localparam int RUNUP = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmp_zero = 1'b1;
  logic [1:0] sw_sel;
  logic done, overflow;
  logic [CNT_W-1:0] result;

  int checks = 0;
  int errors = 0;
  int illegal_sel = 0;
  int vin = 0, vref = 256, vint = 0;
  logic int_clr = 1'b0;

  dslope_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .start(start), .cmp_zero(cmp_zero),
    .sw_sel(sw_sel), .done(done), .overflow(overflow), .result(result)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural integrator, advanced once per cycle from the held switch code
  always @(negedge clk) begin
    if (int_clr) vint = 0;
    else if (sw_sel == 2'b01) vint = vint - vin;
    else if (sw_sel == 2'b10) vint = vint + vref;
    cmp_zero = (vint >= 0);
    if (!rst && sw_sel == 2'b11) illegal_sel++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expect_res(input int vi, input int vr);
    int m;
    if (vi == 0) return 0;
    m = (RUNUP * vi + vr - 1) / vr;
    return m + 1;
  endfunction

  // one conversion; inj >= 0 pulses start in that discharge cycle
  task automatic run_conv(input int vi, input int vr, input int inj,
                          output int res, output int ovf, output int in_cyc,
                          output int bad_tr, output int early_chg, output int pulse_ok);
    int guard;
    int nref;
    logic [1:0] prev;
    logic [CNT_W-1:0] res0;
    vin = vi; vref = vr;
    @(negedge clk); int_clr = 1'b1;
    @(negedge clk); int_clr = 1'b0; start = 1'b1;
    res0 = result;
    @(negedge clk); start = 1'b0;
    in_cyc = 0; bad_tr = 0; early_chg = 0; nref = 0; guard = 0;
    prev = 2'b01;
    if (sw_sel != 2'b01) bad_tr++;
    while (!done && guard < 2000) begin
      if (sw_sel == 2'b01) in_cyc++;
      if (prev == 2'b01 && sw_sel == 2'b00) bad_tr++;
      if (prev == 2'b10 && sw_sel == 2'b01) bad_tr++;
      if (result != res0) early_chg++;
      if (sw_sel == 2'b10) begin
        start = (nref == inj);
        nref++;
      end else start = 1'b0;
      prev = sw_sel;
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    res = int'(result); ovf = int'(overflow);
    pulse_ok = (done && sw_sel == 2'b00) ? 1 : 0;
    @(negedge clk);
    if (done) pulse_ok = 0;
  endtask

  task automatic t_reset;
    chk(sw_sel == 2'b00, "R1", "sw_sel in reset", int'(sw_sel), 0);
    chk(!done && !overflow, "R1", "done/overflow in reset", int'({done, overflow}), 0);
    chk(result == '0, "R1", "result in reset", int'(result), 0);
  endtask

  task automatic t_basic(input int vi, input int vr);
    int res, ovf, inc, btr, ec, po;
    run_conv(vi, vr, -1, res, ovf, inc, btr, ec, po);
    chk(inc == RUNUP, "R2", "charge cycles", inc, RUNUP);
    chk(btr == 0, "R3", "phase order errors", btr, 0);
    chk(res == expect_res(vi, vr), "R4", "result", res, expect_res(vi, vr));
    chk(ovf == 0, "R6", "no overflow", ovf, 0);
    chk(po == 1, "R5", "done pulse with ground select", po, 1);
    chk(ec == 0, "R7", "result changed before done", ec, 0);
  endtask

  task automatic t_zero_input;
    int res, ovf, inc, btr, ec, po;
    run_conv(0, 256, -1, res, ovf, inc, btr, ec, po);
    chk(res == 0 && ovf == 0, "R4", "zero input result", res, 0);
  endtask

  task automatic t_overflow;
    int res, ovf, inc, btr, ec, po;
    run_conv(254, 256, -1, res, ovf, inc, btr, ec, po);
    chk(res == 255, "R6", "full-scale result", res, 255);
    chk(ovf == 0, "R6", "full-scale no overflow", ovf, 0);
    run_conv(255, 256, -1, res, ovf, inc, btr, ec, po);
    chk(ovf == 1, "R6", "overflow flag", ovf, 1);
    chk(res == 255, "R6", "overflow result", res, 255);
    chk(po == 1, "R6", "overflow done pulse", po, 1);
    run_conv(256, 256, -1, res, ovf, inc, btr, ec, po);
    chk(ovf == 1, "R6", "overflow at equal input", ovf, 1);
  endtask

  task automatic t_hold;
    int res, ovf, inc, btr, ec, po;
    logic [CNT_W-1:0] r0;
    logic o0;
    r0 = result; o0 = overflow;
    repeat (20) @(negedge clk);
    chk(result == r0 && overflow == o0, "R7", "hold while idle", int'(result), int'(r0));
    run_conv(37, 256, -1, res, ovf, inc, btr, ec, po);
    chk(ec == 0, "R7", "hold during conversion", ec, 0);
    chk(ovf == 0 && res == 38, "R7", "overflow cleared, new result", res, 38);
  endtask

  task automatic t_start_ignored;
    int res, ovf, inc, btr, ec, po;
    run_conv(100, 256, 10, res, ovf, inc, btr, ec, po);
    chk(btr == 0, "R8", "start in discharge changed switch", btr, 0);
    chk(res == expect_res(100, 256), "R8", "result after mid start", res, expect_res(100, 256));
    // start in the done cycle
    vin = 50; vref = 200;
    @(negedge clk); int_clr = 1'b1;
    @(negedge clk); int_clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int g = 0;
      while (!done && g < 2000) begin g++; @(negedge clk); end
    end
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(sw_sel == 2'b00, "R8", "start in done cycle", int'(sw_sel), 0);
    @(negedge clk);
    chk(sw_sel == 2'b00, "R8", "still idle after done", int'(sw_sel), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic(100, 256);
    t_basic(50, 200);
    t_basic(7, 300);
    t_zero_input();
    t_overflow();
    t_hold();
    t_start_ignored();
    chk(illegal_sel == 0, "R9", "illegal switch codes seen", illegal_sel, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule